// File: doc/BRIEF.md
# Guard-Round-Sticky Significand Rounder

This block takes a significand that has already been normalized and is much wider than the format allows. It cuts the significand to 33 bits: a hidden bit followed by 32 fraction bits. The two bits just below the kept least significant bit act as guard and round. Every bit below those two, together with a sticky flag carried in from the alignment stage, folds into a single sticky bit.

The result sign and a 2-bit mode code choose whether the kept part is incremented. The increment uses one spare high bit. When the kept part overflows, the block returns the top 33 bits of the sum and raises an exponent-increment flag, so the exponent stage downstream can adjust. An inexact flag reports whether any discarded bit was nonzero.

An integer-bypass flag lets integer results, such as a left shift, pass through the same path with rounding switched off. A parameter selects whether the outputs are registered. In the default build they are registered and appear one clock after the valid strobe.

Top module: `fp_grs_rounder`

## Requirements
- R1: The input `sigIn` (101 bits by default) is split into fields. Bits [100:68] are the kept significand, bit 67 is guard, bit 66 is round, and bits [65:0] form the tail. `roundMode` selects the rounding: 2'b00 is nearest-even, 2'b01 is toward zero, 2'b10 is toward +infinity and 2'b11 is toward -infinity.
- R2: In nearest-even mode the kept part is unchanged when guard is 0. It is incremented when guard is 1 and round or sticky is 1. On an exact tie (guard 1, round 0, sticky 0) it is incremented only when the kept LSB is 1.
- R3: In toward-zero mode the kept part is never incremented and `expInc` stays 0.
- R4: Toward +infinity increments when guard|round|sticky is 1 and `signIn` is 0. Toward -infinity increments under the same condition when `signIn` is 1. Neither mode increments for the opposite sign.
- R5: The effective sticky bit is `stickyIn` ORed with every tail bit. A single 1 in any tail bit, including bit 0, counts the same as `stickyIn`.
- R6: The increment is computed 34 bits wide. On carry-out, `sigOut` is the 33 most significant bits of the sum (a 1 followed by 32 zeros) and `expInc` is 1. Otherwise `expInc` is 0.
- R7: `inexact` equals guard|round|sticky, whether or not an increment happens.
- R8: When `intBypass` is 1, `sigOut` equals the kept field unchanged, and `expInc` and `inexact` are 0, whatever the mode, sign and lower bits.
- R9: With the default output register, the results of a vector strobed by `inValid` appear on the next rising clock edge, and `outValid` follows `inValid` one cycle later. While `inValid` is 0 the outputs hold their values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input vector strobe |
| sigIn | input | 101 | Normalized significand: kept bits, guard, round, tail |
| stickyIn | input | 1 | Sticky flag from alignment |
| signIn | input | 1 | Sign of the result |
| roundMode | input | 2 | Rounding mode code |
| intBypass | input | 1 | Pass the kept field through without rounding |
| outValid | output | 1 | Result strobe |
| sigOut | output | 33 | Rounded significand |
| expInc | output | 1 | Carry-out of the increment; exponent must be raised by one |
| inexact | output | 1 | Some discarded bit was nonzero |

## Verification
A wrong increment decision shows up on `sigOut` as an LSB that is off by one, one cycle after the strobe. This happens for a single vector only, because no state carries over from one vector to the next. Faults in the sticky merge show up only when the sole nonzero bit lies deep in the tail or in `stickyIn` alone, so the vectors place isolated ones there. A broken carry path shows up only on all-ones kept fields, as a wrong `expInc` or a significand that wrapped to zero.

// File: rtl/fp_grs_rounder_pkg.sv
package fp_grs_rounder_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_POS_INF   = 2'b10,
    RND_NEG_INF   = 2'b11
  } rndMode_e;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic incEn;
    logic passThru;
  } rndStrobe_t;

endpackage

// File: rtl/fp_grs_rounder_ctrl.sv
module fp_grs_rounder_ctrl
  import fp_grs_rounder_pkg::*;
(
  input  logic       guardBit,
  input  logic       roundBit,
  input  logic       stickyBit,
  input  logic       lsbBit,
  input  logic       signIn,
  input  logic [1:0] roundMode,
  input  logic       intBypass,
  output rndStrobe_t strobes,
  output logic       inexact
);

  logic anyLost;
  logic wantInc;
  rndMode_e modeSel;

  assign modeSel = rndMode_e'(roundMode);
  assign anyLost = guardBit | roundBit | stickyBit;

  always_comb begin
    wantInc = 1'b0;
    unique case (modeSel)
      RND_NEAR_EVEN: begin
        if (guardBit) begin
          if (roundBit | stickyBit) wantInc = 1'b1;
          else                      wantInc = lsbBit;
        end
      end
      RND_ZERO:    wantInc = 1'b0;
      RND_POS_INF: wantInc = anyLost & ~signIn;
      RND_NEG_INF: wantInc = anyLost & signIn;
      default:     wantInc = 1'b0;
    endcase
  end

  always_comb begin
    strobes.passThru = intBypass;
    strobes.incEn    = wantInc & ~intBypass;
    inexact          = anyLost & ~intBypass;
  end

endmodule

// File: rtl/fp_grs_rounder_dp.sv
module fp_grs_rounder_dp
  import fp_grs_rounder_pkg::*;
#(
  parameter int SIG_W  = 33,
  parameter int TAIL_W = 66,
  localparam int IN_W  = SIG_W + 2 + TAIL_W
) (
  input  logic [IN_W-1:0]  sigIn,
  input  logic             stickyIn,
  input  rndStrobe_t       strobes,
  output logic             guardBit,
  output logic             roundBit,
  output logic             stickyBit,
  output logic             lsbBit,
  output logic [SIG_W-1:0] sigOut,
  output logic             expInc
);

  logic [SIG_W-1:0] keptSig;
  logic [TAIL_W-1:0] tailBits;
  logic [SIG_W:0]   incSum;

  assign keptSig   = sigIn[IN_W-1 -: SIG_W];
  assign guardBit  = sigIn[TAIL_W+1];
  assign roundBit  = sigIn[TAIL_W];
  assign tailBits  = sigIn[TAIL_W-1:0];
  assign stickyBit = stickyIn | (|tailBits);
  assign lsbBit    = keptSig[0];

  // one spare bit catches the carry-out of an all-ones significand
  assign incSum = {1'b0, keptSig} + {{SIG_W{1'b0}}, strobes.incEn};

  always_comb begin
    if (strobes.passThru) begin
      sigOut = keptSig;
      expInc = 1'b0;
    end else if (incSum[SIG_W]) begin
      sigOut = incSum[SIG_W:1];
      expInc = 1'b1;
    end else begin
      sigOut = incSum[SIG_W-1:0];
      expInc = 1'b0;
    end
  end

endmodule

// File: rtl/fp_grs_rounder.sv
module fp_grs_rounder
  import fp_grs_rounder_pkg::*;
#(
  parameter int SIG_W   = 33,
  parameter int TAIL_W  = 66,
  parameter bit OUT_REG = 1'b1,
  localparam int IN_W   = SIG_W + 2 + TAIL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  sigIn,
  input  logic             stickyIn,
  input  logic             signIn,
  input  logic [1:0]       roundMode,
  input  logic             intBypass,
  output logic             outValid,
  output logic [SIG_W-1:0] sigOut,
  output logic             expInc,
  output logic             inexact
);

  rndStrobe_t       strobes;
  logic             guardBit, roundBit, stickyBit, lsbBit;
  logic [SIG_W-1:0] sigComb;
  logic             expIncComb;
  logic             inexactComb;

  fp_grs_rounder_dp #(.SIG_W(SIG_W), .TAIL_W(TAIL_W)) u_dp (
    .sigIn     (sigIn),
    .stickyIn  (stickyIn),
    .strobes   (strobes),
    .guardBit  (guardBit),
    .roundBit  (roundBit),
    .stickyBit (stickyBit),
    .lsbBit    (lsbBit),
    .sigOut    (sigComb),
    .expInc    (expIncComb)
  );

  fp_grs_rounder_ctrl u_ctrl (
    .guardBit  (guardBit),
    .roundBit  (roundBit),
    .stickyBit (stickyBit),
    .lsbBit    (lsbBit),
    .signIn    (signIn),
    .roundMode (roundMode),
    .intBypass (intBypass),
    .strobes   (strobes),
    .inexact   (inexactComb)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid <= 1'b0;
          sigOut   <= '0;
          expInc   <= 1'b0;
          inexact  <= 1'b0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            sigOut  <= sigComb;
            expInc  <= expIncComb;
            inexact <= inexactComb;
          end
        end
      end
    end else begin : g_comb
      assign outValid = inValid;
      assign sigOut   = sigComb;
      assign expInc   = expIncComb;
      assign inexact  = inexactComb;
    end
  endgenerate

endmodule

// File: rtl/fp_grs_rounder_chk.sv
module fp_grs_rounder_chk #(
  parameter int SIG_W   = 33,
  parameter int TAIL_W  = 66,
  parameter bit OUT_REG = 1'b1,
  localparam int IN_W   = SIG_W + 2 + TAIL_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [IN_W-1:0]  sigIn,
  input logic             stickyIn,
  input logic [1:0]       roundMode,
  input logic             intBypass,
  input logic             outValid,
  input logic [SIG_W-1:0] sigOut,
  input logic             expInc,
  input logic             inexact
);

  localparam logic [SIG_W-1:0] TOP_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

  generate
    if (OUT_REG) begin : g_chk
      // R9
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> outValid == $past(inValid));

      // R9
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(sigOut) && $stable(expInc) && $stable(inexact));

      // R8
      bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid && intBypass |=>
          sigOut == $past(sigIn[IN_W-1 -: SIG_W]) && !expInc && !inexact);

      // R3
      to_zero_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid && !intBypass && roundMode == 2'b01 |=>
          sigOut == $past(sigIn[IN_W-1 -: SIG_W]) && !expInc);

      // R7
      inexact_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid && !intBypass |=>
          inexact == $past((|sigIn[TAIL_W+1:0]) | stickyIn));

      // R6
      carry_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
        outValid && expInc |-> sigOut == TOP_ONLY);
    end
  endgenerate

endmodule

bind fp_grs_rounder fp_grs_rounder_chk #(
  .SIG_W(SIG_W), .TAIL_W(TAIL_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .sigIn     (sigIn),
  .stickyIn  (stickyIn),
  .roundMode (roundMode),
  .intBypass (intBypass),
  .outValid  (outValid),
  .sigOut    (sigOut),
  .expInc    (expInc),
  .inexact   (inexact)
);

// File: tb/fp_grs_rounder_bench.sv
`timescale 1ns/1ps
module fp_grs_rounder_bench;

  localparam int SIG_W  = 33;
  localparam int TAIL_W = 66;
  localparam int IN_W   = SIG_W + 2 + TAIL_W;
  localparam int REM_W  = TAIL_W + 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [IN_W-1:0]  sigIn = '0;
  logic             stickyIn = 1'b0;
  logic             signIn = 1'b0;
  logic [1:0]       roundMode = 2'b00;
  logic             intBypass = 1'b0;
  logic             outValid;
  logic [SIG_W-1:0] sigOut;
  logic             expInc;
  logic             inexact;

  int vecCount = 0;
  int missCount = 0;

  // pending expectation (one-cycle latency)
  logic             pendValid = 1'b0;
  logic             expOutValid = 1'b0;
  logic [SIG_W-1:0] expSig = '0;
  logic             expCarry = 1'b0;
  logic             expInexact = 1'b0;
  string            pendTag = "R9";

  always #2 clk = ~clk;

  fp_grs_rounder u_fp_grs_rounder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sigIn(sigIn),
    .stickyIn(stickyIn), .signIn(signIn), .roundMode(roundMode),
    .intBypass(intBypass), .outValid(outValid), .sigOut(sigOut),
    .expInc(expInc), .inexact(inexact)
  );

  task automatic compare_now();
    vecCount++;
    if (outValid !== expOutValid || sigOut !== expSig ||
        expInc !== expCarry || inexact !== expInexact) begin
      missCount++;
      $display("FAIL %s: got v=%b sig=%h inc=%b inx=%b, expected v=%b sig=%h inc=%b inx=%b",
               pendTag, outValid, sigOut, expInc, inexact,
               expOutValid, expSig, expCarry, expInexact);
    end
  endtask

  // reference: compare the exact discarded remainder against one half
  task automatic model(input logic [IN_W-1:0] s, input logic stk, input logic sgn,
                       input logic [1:0] md, input logic byp);
    logic [SIG_W-1:0] kept;
    logic [REM_W-1:0] remBits;
    logic [REM_W-1:0] half;
    logic             exact, up;
    logic [SIG_W:0]   sum;
    kept    = s[IN_W-1 -: SIG_W];
    remBits = s[REM_W-1:0];
    half    = '0;
    half[REM_W-1] = 1'b1;
    exact   = (remBits == '0) && !stk;
    up      = 1'b0;
    case (md)
      2'b00: begin
        if (remBits > half || (remBits == half && stk)) up = 1'b1;
        else if (remBits == half && !stk)               up = kept[0];
      end
      2'b10: up = !exact && !sgn;
      2'b11: up = !exact && sgn;
      default: up = 1'b0;
    endcase
    if (byp) begin
      expSig = kept; expCarry = 1'b0; expInexact = 1'b0;
    end else begin
      sum = {1'b0, kept} + (up ? 1 : 0);
      expCarry   = sum[SIG_W];
      expSig     = sum[SIG_W] ? sum[SIG_W:1] : sum[SIG_W-1:0];
      expInexact = !exact;
    end
  endtask

  task automatic apply(input logic [IN_W-1:0] s, input logic stk, input logic sgn,
                       input logic [1:0] md, input logic byp, input string tag);
    @(negedge clk);
    if (pendValid) compare_now();
    sigIn = s; stickyIn = stk; signIn = sgn; roundMode = md; intBypass = byp;
    inValid = 1'b1;
    model(s, stk, sgn, md, byp);
    expOutValid = 1'b1;
    pendTag = tag;
    pendValid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pendValid) compare_now();
      inValid = 1'b0;
      sigIn = '1; stickyIn = 1'b1; roundMode = 2'b10;
      expOutValid = 1'b0;
      pendTag = "R9 hold";
      pendValid = 1'b1;
    end
  endtask

  function automatic logic [IN_W-1:0] mk(input logic [SIG_W-1:0] kept,
                                          input logic g, input logic r,
                                          input logic [TAIL_W-1:0] tail);
    return {kept, g, r, tail};
  endfunction

  function automatic logic [IN_W-1:0] rnd();
    logic [127:0] t;
    t = {$urandom, $urandom, $urandom, $urandom};
    return t[IN_W-1:0];
  endfunction

  initial begin
    #200000;
    missCount++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    logic [SIG_W-1:0] ones;
    logic [TAIL_W-1:0] oneLow;
    ones = '1;
    oneLow = '0; oneLow[0] = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    expOutValid = 1'b0; expSig = '0; expCarry = 1'b0; expInexact = 1'b0;
    pendTag = "R9 reset"; compare_now();
    rstN = 1'b1;
    @(negedge clk);
    pendTag = "R9 reset"; compare_now();

    // R2 ties and beyond-half
    apply(mk(33'h0_0000_0010, 1, 0, '0), 0, 0, 2'b00, 0, "R2 tie even");
    apply(mk(33'h0_0000_0011, 1, 0, '0), 0, 0, 2'b00, 0, "R2 tie odd");
    apply(mk(33'h0_0000_0010, 1, 1, '0), 0, 0, 2'b00, 0, "R2 above half");
    apply(mk(33'h0_0000_0011, 0, 1, '1), 1, 0, 2'b00, 0, "R2 below half");
    // R5 sticky sources
    apply(mk(33'h0_0000_0010, 1, 0, '0), 1, 0, 2'b00, 0, "R5 sticky input");
    apply(mk(33'h0_0000_0010, 1, 0, oneLow), 0, 0, 2'b00, 0, "R5 tail bit0");
    apply(mk(33'h0_0000_0010, 0, 0, oneLow), 0, 0, 2'b10, 0, "R5 R7 tail only");
    // R3 toward zero
    apply(mk(ones, 1, 1, '1), 1, 0, 2'b01, 0, "R3 toward zero");
    // R4 directed
    apply(mk(33'h1_2345_6789, 0, 0, oneLow), 0, 0, 2'b10, 0, "R4 +inf pos");
    apply(mk(33'h1_2345_6789, 0, 0, oneLow), 0, 1, 2'b10, 0, "R4 +inf neg");
    apply(mk(33'h1_2345_6789, 0, 1, '0), 0, 1, 2'b11, 0, "R4 -inf neg");
    apply(mk(33'h1_2345_6789, 0, 1, '0), 0, 0, 2'b11, 0, "R4 -inf pos");
    apply(mk(33'h1_2345_6789, 0, 0, '0), 0, 1, 2'b11, 0, "R7 exact");
    // R6 carry-out in each incrementing mode
    apply(mk(ones, 1, 0, '0), 0, 0, 2'b00, 0, "R6 carry near");
    apply(mk(ones, 0, 0, oneLow), 0, 0, 2'b10, 0, "R6 carry +inf");
    apply(mk(ones, 0, 1, '0), 0, 1, 2'b11, 0, "R6 carry -inf");
    // R8 bypass
    apply(mk(ones, 1, 1, '1), 1, 0, 2'b00, 1, "R8 bypass");
    apply(mk(33'h0_ABCD_0001, 1, 0, '0), 0, 1, 2'b11, 1, "R8 bypass");
    // R9 hold
    idle(3);
    // R1 random and tie-heavy
    for (int i = 0; i < 600; i++) begin
      logic [IN_W-1:0] v;
      logic [1:0] m;
      v = rnd();
      m = 2'($urandom);
      if (i % 3 == 0) v[TAIL_W+1:0] = {2'b10, {TAIL_W{1'b0}}};
      if (i % 7 == 0) v[IN_W-1 -: SIG_W] = ones;
      apply(v, ($urandom % 4) == 0, 1'($urandom), m, (i % 11) == 0, "R1 random");
      if (i % 50 == 0) idle(1);
    end
    idle(1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule